// File: doc/BRIEF.md
# UART Status Flags with Sequenced Clearing

This block holds the eight status flags of a UART and decides when each one is set and when it may be cleared. Level conditions from the transmitter and the FIFOs (room in the transmit FIFO, transmitter idle, receive FIFO at its watermark) and single-cycle event pulses from the receiver (idle line, overrun, noise, framing error, parity error) set the flags. Software clears a flag in two ordered steps. First it reads the status register while the flag is 1, which arms that flag. Later it accesses the data register: a read clears the armed receive-type flags and a write clears the armed transmit-type flags.

A flag that is routed to DMA is also cleared by a DMA-done pulse for that flag. A level-driven flag whose condition still holds stays at 1 through any clear. Each flag drives either the shared interrupt line or its own DMA request line, depending on its enable and routing bits. The serial datapath and the FIFOs are outside this block. The data register's contents are not produced here, so only its address matters.

Top module: `uart_status_flags`

## Requirements
- R1: While reset is asserted, and in the first cycle after reset, the status value is 0xC0 (both transmit flags set) and no flag is armed.
- R2: The read value places transmit-empty at bit 7, transmit-complete at bit 6, receive-full at bit 5, idle-line at bit 4, overrun at bit 3, noise at bit 2, framing at bit 1 and parity at bit 0. `rd_data` shows the flags whenever `bus_addr` equals the status address, with or without a strobe, and is 0 at any other address. A set input becomes visible one cycle after the clock edge that samples it.
- R3: A data-register read clears every receive-type flag (bits 5..0) that a status read saw at 1 earlier. The cleared value is visible after that edge.
- R4: A data-register write clears every transmit-type flag (bits 7..6) that a status read saw at 1 earlier.
- R5: A data access with no arming status read before it clears nothing. A data write leaves receive-type flags set, and a data read leaves transmit-type flags set.
- R6: Accesses to other addresses, and repeated status reads, between the status read and the data access do not break the clear sequence.
- R7: A status read made while a flag is 0 does not arm it. An event that sets the flag after that read survives the next data access.
- R8: A `dma_done` pulse clears its flag when `dma_sel` routes that flag to DMA. It has no effect on a flag that is not routed to DMA.
- R9: A flag whose set condition is still active stays 1 after any clearing action.
- R10: A write to the status address changes no flag and arms nothing.
- R11: `irq_req` is 1 when any set flag is enabled and not routed to DMA. `dma_req[i]` is 1 when flag i is set, enabled and routed to DMA.
- R12: When a set event arrives in the same cycle as the access that would clear its flag, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Register address of the bus access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| rd_data | output | 8 | Status value when the status address is selected, else 0 |
| tx_space_ok | input | 1 | Level: transmit FIFO at or below its watermark |
| tx_idle | input | 1 | Level: transmitter has finished all activity |
| rx_level_ok | input | 1 | Level: receive FIFO at or above its watermark |
| idle_det | input | 1 | Pulse: idle line detected |
| overrun_det | input | 1 | Pulse: receive overrun |
| noise_det | input | 1 | Pulse: noise seen on a received frame |
| frame_det | input | 1 | Pulse: framing error |
| parity_det | input | 1 | Pulse: parity error |
| irq_en | input | 8 | Per-flag request enable, same bit order as the status value |
| dma_sel | input | 8 | Per-flag routing to DMA instead of interrupt |
| dma_done | input | 8 | Per-flag DMA completion pulse |
| irq_req | output | 1 | Shared interrupt request |
| dma_req | output | 8 | Per-flag DMA request |

## Verification
The assertions assume that a read and a write strobe never occur in the same cycle, so each cycle carries at most one bus access. They also assume that a flag counts as routed to DMA only through `dma_sel`. The stimulus drives each bus operation as a single strobe cycle and then idles the bus. Condition levels and event pulses change only away from the bus strobes, except in the one case that tests a set event coinciding with a clear. Observations use the status address with no strobe, so checking a flag never arms it.

// File: rtl/uart_status_flags.sv
module uart_status_flags #(
  parameter int ADDR_W = 3,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 3'd4,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 3'd7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  output logic [7:0]        rd_data,
  input  logic              tx_space_ok,
  input  logic              tx_idle,
  input  logic              rx_level_ok,
  input  logic              idle_det,
  input  logic              overrun_det,
  input  logic              noise_det,
  input  logic              frame_det,
  input  logic              parity_det,
  input  logic [7:0]        irq_en,
  input  logic [7:0]        dma_sel,
  input  logic [7:0]        dma_done,
  output logic              irq_req,
  output logic [7:0]        dma_req
);
  localparam logic [7:0] TX_MASK = 8'hC0;
  localparam logic [7:0] RX_MASK = 8'h3F;
  localparam logic [7:0] RST_VAL = TX_MASK;

  logic [7:0] flags, armed, set_vec, clr_vec, flags_nx, armed_nx;
  logic stat_rd, data_rd, data_wr;

  assign stat_rd = bus_rd && bus_addr == STAT_ADDR;
  assign data_rd = bus_rd && bus_addr == DATA_ADDR;
  assign data_wr = bus_wr && bus_addr == DATA_ADDR;

  assign set_vec = {tx_space_ok, tx_idle, rx_level_ok, idle_det,
                    overrun_det, noise_det, frame_det, parity_det};

  always_comb begin
    clr_vec = dma_done & dma_sel;
    if (data_rd) clr_vec = clr_vec | (armed & RX_MASK);
    if (data_wr) clr_vec = clr_vec | (armed & TX_MASK);
    flags_nx = (flags & ~clr_vec) | set_vec;
    armed_nx = armed;
    if (stat_rd) armed_nx = armed_nx | flags;
    if (data_rd) armed_nx = armed_nx & ~RX_MASK;
    if (data_wr) armed_nx = armed_nx & ~TX_MASK;
    armed_nx = armed_nx & ~(dma_done & dma_sel) & flags_nx;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags <= RST_VAL;
      armed <= '0;
    end else begin
      flags <= flags_nx;
      armed <= armed_nx;
    end
  end

  assign rd_data = (bus_addr == STAT_ADDR) ? flags : 8'h00;
  assign irq_req = |(flags & irq_en & ~dma_sel);
  assign dma_req = flags & irq_en & dma_sel;
endmodule

module uart_status_flags_chk #(
  parameter int ADDR_W = 3,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 3'd4,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 3'd7
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic              tx_space_ok,
  input logic              tx_idle,
  input logic              rx_level_ok,
  input logic              idle_det,
  input logic              overrun_det,
  input logic              noise_det,
  input logic              frame_det,
  input logic              parity_det,
  input logic [7:0]        dma_sel,
  input logic [7:0]        dma_done,
  input logic [7:0]        flags,
  input logic [7:0]        armed
);
  logic [7:0] setv;
  logic drd, dwr, swr, dma_any;
  assign setv = {tx_space_ok, tx_idle, rx_level_ok, idle_det,
                 overrun_det, noise_det, frame_det, parity_det};
  assign drd = bus_rd && bus_addr == DATA_ADDR;
  assign dwr = bus_wr && bus_addr == DATA_ADDR;
  assign swr = bus_wr && bus_addr == STAT_ADDR;
  assign dma_any = |(dma_done & dma_sel);

  AST_RESET_VALUE: assert property (@(posedge clk)
    !rst_n |=> (flags == 8'hC0 && armed == 8'h00)); // R1

  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!drd && !dma_any) |=> ((flags & 8'h3F) & $past(flags)) == ($past(flags) & 8'h3F)); // R5

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!dwr && !dma_any) |=> ((flags & 8'hC0) & $past(flags)) == ($past(flags) & 8'hC0)); // R5

  AST_RX_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (drd && setv == 8'h00) |=> (flags & $past(armed) & 8'h3F) == 8'h00); // R3

  AST_TX_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (dwr && setv == 8'h00) |=> (flags & $past(armed) & 8'hC0) == 8'h00); // R4

  AST_DMA_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    dma_any |=> (flags & $past(dma_done & dma_sel & ~setv)) == 8'h00); // R8

  AST_LEVEL_PERSIST: assert property (@(posedge clk) disable iff (!rst_n)
    tx_space_ok |=> flags[7]); // R9

  AST_STATUS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (swr && !dma_any) |=> ($past(flags) & ~flags) == 8'h00); // R10
endmodule

bind uart_status_flags uart_status_flags_chk #(
  .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR), .DATA_ADDR(DATA_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .tx_space_ok(tx_space_ok), .tx_idle(tx_idle), .rx_level_ok(rx_level_ok),
  .idle_det(idle_det), .overrun_det(overrun_det), .noise_det(noise_det),
  .frame_det(frame_det), .parity_det(parity_det), .dma_sel(dma_sel),
  .dma_done(dma_done), .flags(flags), .armed(armed)
);

// File: tb/uart_status_flags_bench.sv
`timescale 1ns/100ps
module uart_status_flags_bench;
  localparam logic [2:0] SA = 3'd4;
  localparam logic [2:0] DA = 3'd7;
  localparam logic [2:0] OA = 3'd1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] bus_addr = OA;
  logic bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] rd_data;
  logic tx_space_ok = 0, tx_idle = 0, rx_level_ok = 0;
  logic idle_det = 0, overrun_det = 0, noise_det = 0, frame_det = 0, parity_det = 0;
  logic [7:0] irq_en = 0, dma_sel = 0, dma_done = 0;
  logic irq_req;
  logic [7:0] dma_req;

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct {
    logic [7:0] flg;
    logic       irq;
    logic [7:0] dma;
    logic [7:0] other;
    string      tag;
  } item_t;
  item_t q[$];

  always #2.5 clk = ~clk;

  uart_status_flags u_uart_status_flags (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .rd_data(rd_data), .tx_space_ok(tx_space_ok), .tx_idle(tx_idle),
    .rx_level_ok(rx_level_ok), .idle_det(idle_det), .overrun_det(overrun_det),
    .noise_det(noise_det), .frame_det(frame_det), .parity_det(parity_det),
    .irq_en(irq_en), .dma_sel(dma_sel), .dma_done(dma_done),
    .irq_req(irq_req), .dma_req(dma_req)
  );

  // monitor: pops at the falling edge, reading status with no strobe
  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (rd_data !== it.flg) begin
        errors++;
        $display("FAIL %s flags actual %h expected %h", it.tag, rd_data, it.flg);
      end else if (irq_req !== it.irq || dma_req !== it.dma) begin
        errors++;
        $display("FAIL %s irq/dma actual %b/%h expected %b/%h", it.tag, irq_req, dma_req, it.irq, it.dma);
      end
    end
  end

  task automatic idle_bus();
    bus_rd = 0; bus_wr = 0; bus_addr = OA;
  endtask

  task automatic expect_flags(input logic [7:0] f, input string tag);
    item_t it;
    @(posedge clk); #1;
    idle_bus();
    bus_addr = SA;
    it.flg = f;
    it.irq = |(f & irq_en & ~dma_sel);
    it.dma = f & irq_en & dma_sel;
    it.other = 0;
    it.tag = tag;
    q.push_back(it);
    @(negedge clk); #0.5;
  endtask

  task automatic access(input logic [2:0] a, input bit wr);
    @(posedge clk); #1;
    bus_addr = a; bus_rd = !wr; bus_wr = wr;
    @(posedge clk); #1;
    idle_bus();
  endtask

  task automatic pulse_set(input logic [7:0] v);
    @(posedge clk); #1;
    {tx_space_ok, tx_idle, rx_level_ok, idle_det, overrun_det, noise_det, frame_det, parity_det} = v;
    @(posedge clk); #1;
    {tx_space_ok, tx_idle, rx_level_ok, idle_det, overrun_det, noise_det, frame_det, parity_det} = 8'h00;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    expect_flags(8'hC0, "R1 reset value");
    #1 rst_n = 1'b1;
    expect_flags(8'hC0, "R1 after reset");
    // clear of transmit flags
    access(SA, 0); access(DA, 1);
    expect_flags(8'h00, "R4 write clears tx flags");
    // access without arming
    pulse_set(8'h40);
    expect_flags(8'h40, "R2 tx-complete at bit 6");
    access(DA, 1);
    expect_flags(8'h40, "R5 no status read, no clear");
    pulse_set(8'h01);
    expect_flags(8'h41, "R2 parity at bit 0");
    access(SA, 0); access(DA, 1);
    expect_flags(8'h01, "R5 write leaves rx flag");
    access(DA, 0);
    expect_flags(8'h00, "R3 read clears armed rx flag");
    // interleaved accesses
    pulse_set(8'h02);
    access(SA, 0); access(OA, 0); access(OA, 1); access(SA, 0); access(DA, 0);
    expect_flags(8'h00, "R6 sequence survives other accesses");
    // read with flag low does not arm
    access(SA, 0);
    pulse_set(8'h04);
    access(DA, 0);
    expect_flags(8'h04, "R7 late event survives data read");
    access(SA, 0); access(DA, 0);
    expect_flags(8'h00, "R7 later sequence clears it");
    // persistent level
    @(posedge clk); #1 tx_space_ok = 1;
    expect_flags(8'h80, "R2 tx-empty at bit 7");
    access(SA, 0); access(DA, 1);
    expect_flags(8'h80, "R9 condition holds, flag stays");
    @(posedge clk); #1 tx_space_ok = 0;
    access(SA, 0); access(DA, 1);
    expect_flags(8'h00, "R9 clears once condition gone");
    // write to status address
    pulse_set(8'h08);
    access(SA, 1); access(DA, 0);
    expect_flags(8'h08, "R10 status write does not arm");
    access(SA, 0); access(DA, 0);
    expect_flags(8'h00, "R10 overrun cleared by sequence");
    // DMA routing and requests
    @(posedge clk); #1 irq_en = 8'h30; dma_sel = 8'h20;
    pulse_set(8'h20);
    expect_flags(8'h20, "R11 receive-full raises dma request");
    @(posedge clk); #1 dma_done = 8'h20;
    @(posedge clk); #1 dma_done = 8'h00;
    expect_flags(8'h00, "R8 dma done clears routed flag");
    pulse_set(8'h10);
    expect_flags(8'h10, "R11 idle raises interrupt");
    @(posedge clk); #1 dma_done = 8'h10;
    @(posedge clk); #1 dma_done = 8'h00;
    expect_flags(8'h10, "R8 dma done ignored when not routed");
    access(SA, 0); access(DA, 0);
    expect_flags(8'h00, "R3 idle cleared by sequence");
    @(posedge clk); #1 irq_en = 0; dma_sel = 0;
    // set wins over clear
    pulse_set(8'h01);
    access(SA, 0);
    @(posedge clk); #1;
    bus_addr = DA; bus_rd = 1; parity_det = 1;
    @(posedge clk); #1;
    idle_bus(); parity_det = 0;
    expect_flags(8'h01, "R12 coincident event keeps flag");
    // all sources at once
    pulse_set(8'hFF);
    expect_flags(8'hFF, "R2 full bit layout");
    @(posedge clk); #1 bus_addr = DA;
    @(negedge clk); #0.5;
    checks++;
    if (rd_data !== 8'h00) begin
      errors++;
      $display("FAIL R2 non-status address actual %h expected %h", rd_data, 8'h00);
    end
    repeat (3) @(posedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule